// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache

The block sits between a requester that reads 32-bit words by byte address and a slow word-wide memory. Each byte address is cut into a tag, a set index and a byte offset. The set index picks one of 256 sets. Each set holds four entries, and each entry has a valid flag, a tag and one data word. All four entries of the chosen set are compared with the request tag at once, one comparator per way. A hit returns the word of the matching way through an AND-OR select. Data leaves the block only once the way selection and the hit or miss outcome are both settled.

On a miss the block stops taking requests. It issues a word-address read to memory and holds it until the memory answers. It then writes the returned word into a victim way and hands the word to the requester, flagged as a miss. The victim is the lowest-numbered empty way of the set if one exists. Otherwise it is the way of that set used least recently, tracked with per-set age counters. Those counters are refreshed on every hit and every fill.

Top module: `sa4_cache`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `rsp_valid` and `mem_req` are 0, and every entry is empty, so the first access to any address after reset is a miss.
- R2: Address bits [1:0] are a byte offset and do not affect the lookup. Bits [9:2] select the set and bits [31:10] are the tag. Two addresses that differ only in bits [1:0] return the same word, and the second of them hits.
- R3: When a request accepted with `req_valid` and `req_ready` high finds a valid way with a matching tag, the next cycle shows `rsp_valid`=1, `rsp_hit`=1, `rsp_miss`=0 and `rsp_data` equal to the stored word, and `mem_req` stays 0.
- R4: On a miss, `mem_req` is 1 from the cycle after acceptance, with `mem_addr` equal to request address bits [31:2]. Both stay unchanged until `mem_rvalid` is sampled high, and `req_ready` is 0 for that whole time.
- R5: The cycle after `mem_rvalid` is sampled high during a miss, `rsp_valid`=1, `rsp_miss`=1, `rsp_hit`=0 and `rsp_data` equals `mem_rdata`. `mem_req` drops, `req_ready` returns to 1, and the word is installed so that a later access to it hits.
- R6: A set holds four words with distinct tags at the same time: four misses into an empty set fill the empty ways lowest first and evict none of them.
- R7: When a full set misses, the way whose last hit or fill is the oldest is replaced. Hits refresh recency, so a recently hit word survives and the least recently used one is evicted.
- R8: After reset, alternating eight accesses between byte addresses 0x0 and 0x400 (same set, different tags) gives exactly two misses followed by six hits.
- R9: Sets are independent: filling or replacing entries in one set never evicts entries of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the requested word |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_miss | output | 1 | Response came from memory after a miss |
| rsp_data | output | 32 | Returned word |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 30 | Word address of the memory read |
| mem_rvalid | input | 1 | Memory returns data this cycle |
| mem_rdata | input | 32 | Word returned by memory |

## Verification
The assertions assume a well-behaved memory. It raises `mem_rvalid` only while `mem_req` is high, for one cycle per request, and it never answers unasked. They also assume that `req_valid` drops once a request has been accepted. The bench plays the memory itself and answers each read once, after a latency of zero to two idle cycles. It presents every request for a single accepted cycle and waits for each response before sending the next one. The bench never drives `mem_rvalid` outside a pending miss, so the stall and hold properties are tested only against legal memory behaviour.

// File: rtl/sa4_cache_pkg.sv
// Package: shared constants and types for the four-way read cache.
// Assumes a 32-bit byte address with word granularity (2 offset bits).
package sa4_cache_pkg;

    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 2;
    localparam int WADDR_W = ADDR_W - OFF_W;

    // Controller phase: accepting lookups, or waiting on a memory fill.
    typedef enum logic [0:0] {
        PH_LOOKUP = 1'b0,
        PH_FILL   = 1'b1
    } phase_t;

    // Strip the byte offset from a byte address.
    function automatic logic [WADDR_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF_W];
    endfunction

endpackage

// File: rtl/sa4_way_array.sv
// Module: sa4_way_array
// Holds valid, tag and data for every way of every set and performs the
// parallel tag compare for one set. Read data is an AND-OR select steered
// by the one-hot hit vector. Assumes at most one way per set holds a tag
// (guaranteed by the controller filling only on a miss).
module sa4_way_array #(
    parameter int WAYS   = 4,
    parameter int SET_W  = 8,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32,
    localparam int SETS  = 1 << SET_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output logic [WAYS-1:0]   hit_vec,
    output logic [WAYS-1:0]   valid_vec,
    output logic [DATA_W-1:0] rd_data
);

    logic              valid_q [WAYS][SETS];
    logic [TAG_W-1:0]  tag_q   [WAYS][SETS];
    logic [DATA_W-1:0] data_q  [WAYS][SETS];

    genvar gw;
    generate
        for (gw = 0; gw < WAYS; gw++) begin : g_way
            // Valid flags: cleared on reset, set when this way is filled.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < SETS; s++) valid_q[gw][s] <= 1'b0;
                end else if (wr_en && (wr_way == WAY_W'(gw))) begin
                    valid_q[gw][wr_set] <= 1'b1;
                end
            end

            // Tag and data storage: written on a fill, never reset.
            always_ff @(posedge clk) begin
                if (wr_en && (wr_way == WAY_W'(gw))) begin
                    tag_q[gw][wr_set]  <= wr_tag;
                    data_q[gw][wr_set] <= wr_data;
                end
            end

            // Per-way comparator for the selected set.
            assign valid_vec[gw] = valid_q[gw][rd_set];
            assign hit_vec[gw]   = valid_q[gw][rd_set] && (tag_q[gw][rd_set] == rd_tag);
        end
    endgenerate

    // Four-to-one AND-OR select driven by the hit vector.
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            rd_data = rd_data | (data_q[w][rd_set] & {DATA_W{hit_vec[w]}});
        end
    end

    // R6: a tag lives in at most one way of a set.
    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/sa4_lru_age.sv
// Module: sa4_lru_age
// Keeps a full recency order per set as one age counter per way
// (0 = newest, WAYS-1 = oldest). An access makes its way age 0 and ages
// every way that was newer than it. Assumes a single update per cycle.
module sa4_lru_age #(
    parameter int WAYS   = 4,
    parameter int SET_W  = 8,
    localparam int SETS  = 1 << SET_W,
    localparam int WAY_W = $clog2(WAYS),
    localparam int AGE_W = WAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    output logic [WAY_W-1:0] oldest_way
);

    logic [AGE_W-1:0] age_q [SETS][WAYS];
    logic [WAYS-1:0]  age_seen;

    // Age update: reset puts way 0 oldest; an access moves its way to newest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= AGE_W'(WAYS - 1 - w);
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way)
                    age_q[upd_set][w] <= '0;
                else if (age_q[upd_set][w] < age_q[upd_set][upd_way])
                    age_q[upd_set][w] <= age_q[upd_set][w] + 1'b1;
            end
        end
    end

    // Oldest way of the looked-up set.
    always_comb begin
        oldest_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (age_q[rd_set][w] == AGE_W'(WAYS - 1)) oldest_way = WAY_W'(w);
    end

    // Which ages occur in the looked-up set (feeds the permutation check).
    always_comb begin
        age_seen = '0;
        for (int w = 0; w < WAYS; w++) age_seen[age_q[rd_set][w]] = 1'b1;
    end

    // R7: ages of a set always form a permutation, so one oldest way exists.
    a_r7_age_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        &age_seen);

endmodule

// File: rtl/sa4_victim_pick.sv
// Module: sa4_victim_pick
// Chooses the way to refill: the lowest-numbered empty way if the set has
// one, otherwise the oldest way reported by the recency tracker.
module sa4_victim_pick #(
    parameter int WAYS   = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [WAY_W-1:0] oldest_way,
    output logic [WAY_W-1:0] victim_way
);

    // Priority scan from the top so the lowest empty way wins.
    always_comb begin
        victim_way = oldest_way;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!valid_vec[w]) victim_way = WAY_W'(w);
    end

    // R6: with any empty way present, the victim is an empty way.
    a_r6_fill_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&valid_vec)) |-> !valid_vec[victim_way]);

endmodule

// File: rtl/sa4_cache.sv
// Module: sa4_cache
// Four-way set-associative read cache, one word per way. Looks up the
// request address combinationally at acceptance and registers the response.
// A miss parks the controller in a fill phase, holds a memory read until it
// is answered, installs the word into the chosen victim and returns it.
// Assumes memory answers once per request, only while mem_req is high.
module sa4_cache
    import sa4_cache_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int SET_W  = 8,
    parameter int DATA_W = 32,
    localparam int TAG_W = ADDR_W - SET_W - OFF_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                mem_req,
    output logic [WADDR_W-1:0]  mem_addr,
    input  logic                mem_rvalid,
    input  logic [DATA_W-1:0]   mem_rdata
);

    phase_t             phase_q;
    logic [WADDR_W-1:0] waddr_q;
    logic [WAY_W-1:0]   victim_q;
    logic               mem_req_q;
    logic               rsp_valid_q, rsp_hit_q, rsp_miss_q;
    logic [DATA_W-1:0]  rsp_data_q;

    logic [WADDR_W-1:0] req_word;
    logic [SET_W-1:0]   req_set, fill_set;
    logic [TAG_W-1:0]   req_tag, fill_tag;
    logic [WAYS-1:0]    hit_vec, valid_vec;
    logic [DATA_W-1:0]  hit_data;
    logic [WAY_W-1:0]   hit_way, oldest_way, victim_way;
    logic               accept, any_hit, fill_done;
    logic               lru_en;
    logic [WAY_W-1:0]   lru_way;
    logic [SET_W-1:0]   lru_set;

    // Address split of the incoming request and of the pending fill.
    assign req_word = word_of(req_addr);
    assign req_set  = req_word[SET_W-1:0];
    assign req_tag  = req_word[WADDR_W-1:SET_W];
    assign fill_set = waddr_q[SET_W-1:0];
    assign fill_tag = waddr_q[WADDR_W-1:SET_W];

    assign req_ready = (phase_q == PH_LOOKUP);
    assign accept    = req_valid && req_ready;
    assign any_hit   = |hit_vec;
    assign fill_done = (phase_q == PH_FILL) && mem_rvalid;

    // Encode the one-hot hit vector into a way number.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    // Recency update source: the hit way on a hit, the victim on a fill.
    assign lru_en  = (accept && any_hit) || fill_done;
    assign lru_way = fill_done ? victim_q : hit_way;
    assign lru_set = fill_done ? fill_set : req_set;

    sa4_way_array #(
        .WAYS(WAYS), .SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_ways (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (req_set),
        .rd_tag    (req_tag),
        .wr_en     (fill_done),
        .wr_set    (fill_set),
        .wr_way    (victim_q),
        .wr_tag    (fill_tag),
        .wr_data   (mem_rdata),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .rd_data   (hit_data)
    );

    sa4_lru_age #(
        .WAYS(WAYS), .SET_W(SET_W)
    ) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_set     (req_set),
        .upd_en     (lru_en),
        .upd_set    (lru_set),
        .upd_way    (lru_way),
        .oldest_way (oldest_way)
    );

    sa4_victim_pick #(
        .WAYS(WAYS)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .oldest_way (oldest_way),
        .victim_way (victim_way)
    );

    // Phase, pending address and victim latched at a missing acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_LOOKUP;
            waddr_q  <= '0;
            victim_q <= '0;
        end else if (accept && !any_hit) begin
            phase_q  <= PH_FILL;
            waddr_q  <= req_word;
            victim_q <= victim_way;
        end else if (fill_done) begin
            phase_q  <= PH_LOOKUP;
        end
    end

    // Memory read request: raised on a miss, dropped once answered.
    always_ff @(posedge clk) begin
        if (!rst_n)                   mem_req_q <= 1'b0;
        else if (accept && !any_hit)  mem_req_q <= 1'b1;
        else if (fill_done)           mem_req_q <= 1'b0;
    end

    // Registered response: hit data after lookup, memory data after fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_miss_q  <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= (accept && any_hit) || fill_done;
            rsp_hit_q   <= accept && any_hit;
            rsp_miss_q  <= fill_done;
            if (fill_done)             rsp_data_q <= mem_rdata;
            else if (accept && any_hit) rsp_data_q <= hit_data;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_miss  = rsp_miss_q;
    assign rsp_data  = rsp_data_q;
    assign mem_req   = mem_req_q;
    assign mem_addr  = waddr_q;

    // R4: an unanswered memory read holds its address on the next cycle.
    a_r4_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R4: no request is accepted while a memory read is pending.
    a_r4_stall_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R5: every response is exactly one of hit or miss.
    a_r5_resp_kind: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

    // R3: a hit response follows an accepted request by one cycle.
    a_r3_hit_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> $past(req_valid && req_ready));

    // R5: a miss response follows a memory answer to a pending read.
    a_r5_miss_follows_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> $past(mem_req && mem_rvalid));

endmodule

// File: tb/sa4_cache_tb.sv
// Bench for sa4_cache: fills every set with four tags, re-reads all of them
// with varied byte offsets, then runs recency, reset and alternation cases.
// The bench acts as the memory; expected data is an arithmetic function of
// the word address.
module sa4_cache_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [31:0] rsp_data;
    logic        mem_req;
    logic [29:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int miss_seen = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sa4_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] word_data(input logic [29:0] wa);
        return (32'(wa) * 32'h0001_0003) ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [31:0] mk_addr(input logic [21:0] tag,
                                            input logic [7:0] set,
                                            input logic [1:0] off);
        return {tag, set, off};
    endfunction

    function automatic logic [21:0] sweep_tag(input int t, input int s);
        return 22'(t * 22'h1357 + s + 1);
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One read; exp_hit says what the requirements predict for this address.
    task automatic access(input logic [31:0] a, input bit exp_hit,
                          input int lat, input string req);
        logic [29:0] wa;
        wa = a[31:2];
        @(negedge clk);
        chk(req_ready == 1'b1, {req, " ready before request"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            chk(rsp_valid && rsp_hit && !rsp_miss, {req, " R3 hit flags"},
                {29'd0, rsp_valid, rsp_hit, rsp_miss}, 32'd6);
            chk(rsp_data == word_data(wa), {req, " R3 hit data"}, rsp_data, word_data(wa));
            chk(mem_req == 1'b0, {req, " R3 no memory read"}, 32'(mem_req), 32'd0);
        end else begin
            chk(!rsp_valid && mem_req && !req_ready, {req, " R4 miss request"},
                {29'd0, rsp_valid, mem_req, req_ready}, 32'd2);
            chk(mem_addr == wa, {req, " R4 word address"}, 32'(mem_addr), 32'(wa));
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk(mem_req && !req_ready && mem_addr == wa && !rsp_valid,
                    {req, " R4 hold while waiting"}, 32'(mem_addr), 32'(wa));
            end
            mem_rvalid = 1'b1;
            mem_rdata  = word_data(wa);
            @(negedge clk);
            mem_rvalid = 1'b0;
            mem_rdata  = '0;
            chk(rsp_valid && rsp_miss && !rsp_hit, {req, " R5 miss flags"},
                {29'd0, rsp_valid, rsp_hit, rsp_miss}, 32'd5);
            chk(rsp_data == word_data(wa), {req, " R5 fill data"}, rsp_data, word_data(wa));
            chk(!mem_req && req_ready, {req, " R5 release"},
                {30'd0, mem_req, req_ready}, 32'd1);
            miss_seen++;
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs after reset.
        chk(req_ready && !rsp_valid && !mem_req, "R1 reset outputs",
            {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);

        // R6, R9: fill four tags in every set, lowest empty way first.
        for (int s = 0; s < 256; s++)
            for (int t = 0; t < 4; t++)
                access(mk_addr(sweep_tag(t, s), 8'(s), 2'd0), 1'b0, (s + t) % 3, "R6 fill");

        // R2, R6, R9: every filled word is still resident, any byte offset.
        for (int s = 0; s < 256; s++)
            for (int t = 0; t < 4; t++)
                access(mk_addr(sweep_tag(t, s), 8'(s), 2'((s + t) % 4)), 1'b1, 0, "R2 R9 reread");

        // R7: set 5 recency after reread is t0..t3 oldest to newest.
        access(mk_addr(sweep_tag(0, 5), 8'd5, 2'd3), 1'b1, 0, "R7 refresh t0");
        access(mk_addr(22'h3ABCD, 8'd5, 2'd0), 1'b0, 1, "R7 new tag evicts t1");
        access(mk_addr(sweep_tag(0, 5), 8'd5, 2'd0), 1'b1, 0, "R7 t0 kept");
        access(mk_addr(sweep_tag(2, 5), 8'd5, 2'd0), 1'b1, 0, "R7 t2 kept");
        access(mk_addr(sweep_tag(3, 5), 8'd5, 2'd0), 1'b1, 0, "R7 t3 kept");
        access(mk_addr(22'h3ABCD, 8'd5, 2'd1), 1'b1, 0, "R7 new tag resident");
        access(mk_addr(sweep_tag(1, 5), 8'd5, 2'd0), 1'b0, 2, "R7 t1 was evicted");
        access(mk_addr(sweep_tag(2, 5), 8'd5, 2'd0), 1'b1, 0, "R7 t2 after t1 refill");
        access(mk_addr(sweep_tag(0, 5), 8'd5, 2'd0), 1'b0, 0, "R7 t0 now evicted");
        // R9: neighbouring sets untouched by the set 5 replacements.
        access(mk_addr(sweep_tag(1, 4), 8'd4, 2'd0), 1'b1, 0, "R9 set 4 intact");
        access(mk_addr(sweep_tag(1, 6), 8'd6, 2'd0), 1'b1, 0, "R9 set 6 intact");

        // R1: reset empties the cache.
        do_reset();
        chk(req_ready && !rsp_valid && !mem_req, "R1 outputs after second reset",
            {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);
        access(mk_addr(sweep_tag(2, 9), 8'd9, 2'd0), 1'b0, 1, "R1 resident word lost");

        // R8: alternate two tags of set 0, eight accesses.
        do_reset();
        miss_seen = 0;
        for (int i = 0; i < 8; i++)
            access((i % 2 == 0) ? 32'h0000_0000 : 32'h0000_0400, i >= 2, 1, "R8 alternate");
        chk(miss_seen == 2, "R8 miss count", 32'(miss_seen), 32'd2);

        repeat (2) @(negedge clk);
        summary();
    end

endmodule